// File: doc/BRIEF.md
# Feature-Parallel Manhattan Distance Unit

This block produces one Manhattan (L1) distance per clock between a sample vector and a reference vector. All features of both operands arrive side by side on two wide input buses. One absolute-difference lane per feature feeds a balanced binary adder tree, so the whole distance is reduced in a single step, with no running accumulator. A build parameter chooses between a purely combinational tree followed by one result register, and a tree with a register at every level for a higher clock rate.

An internal pair walker steps through every (sample, reference) pair of an N-sample by K-reference distance matrix, one pair per clock, for N·K cycles per run. It drives the sample and reference indices out as read addresses. The surrounding memories answer in the same cycle with the two feature vectors. A mode input, captured when a run is accepted, picks sample-major or reference-major order. Each result leaves with a valid flag and the indices of the pair that produced it, delayed to line up with the tree. A one-cycle done pulse follows the last result.

Top module: `mdist_tree_unit`

## Requirements
- R1: Feature m of each operand sits at bits [m·DATA_W +: DATA_W] of its bus and is an unsigned integer. The result equals the sum over all NUM_FEAT features of the absolute difference, and tree inputs beyond NUM_FEAT contribute zero.
- R2: A pair addressed in a given cycle appears at the output ceil(log2 NUM_FEAT) cycles later when PIPE_LEVELS=1, and 1 cycle later when PIPE_LEVELS=0.
- R3: An accepted run yields exactly NUM_SAMP·NUM_REF valid results on consecutive cycles, with no gap.
- R4: With `ref_outer`=0 at the accepted start, pairs come in sample-major order: (0,0),(0,1)…(0,K−1),(1,0)…, with the reference index varying fastest.
- R5: With `ref_outer`=1 at the accepted start, pairs come in reference-major order: (0,0),(1,0)…(N−1,0),(0,1)…, with the sample index varying fastest.
- R6: In the cycle after a start is accepted, the read addresses are (0,0). Each result's `out_n`/`out_k` name the pair it was computed from, and both stay within range.
- R7: `done` is high for exactly one cycle, in the cycle right after the final valid result, and that final result is always pair (N−1,K−1).
- R8: A `start` received while a run is in progress is ignored. `ref_outer` is sampled only when a start is accepted.
- R9: During and after reset, `out_valid` and `done` stay low until the next start, and a run cut short by reset does not resume.
- R10: The result width is DATA_W+ceil(log2 NUM_FEAT), and a full-scale input (every difference at its maximum) gives NUM_FEAT·(2^DATA_W−1) without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run at pair (0,0) when idle |
| ref_outer | input | 1 | Order select captured at start: 0 sample-major, 1 reference-major |
| req_n | output | N_W | Sample read address for the current pair |
| req_k | output | K_W | Reference read address for the current pair |
| samp_vec | input | NUM_FEAT·DATA_W | Sample features for the addressed pair |
| ref_vec | input | NUM_FEAT·DATA_W | Reference features for the addressed pair |
| out_valid | output | 1 | Result valid |
| out_n | output | N_W | Sample index of the result |
| out_k | output | K_W | Reference index of the result |
| out_dist | output | SUM_W | Manhattan distance |
| done | output | 1 | One-cycle pulse after the final result |

## Verification
The bench builds two copies side by side, one with a pipelined tree and one with a combinational tree. Both use five features of eight bits, four samples and three references. Five features leave three padded tree inputs and need three levels, so latencies of 3 and 1 can both be checked against the same stimulus. Four by three is not square, so the two walk orders give visibly different index sequences and the wrap of each index can be observed. All-zero against all-255 data drives the widest sum, 1275, through the eleven-bit result.

// File: rtl/mdist_pkg.sv
package mdist_pkg;

    typedef enum logic {
        ORD_SAMP_OUTER = 1'b0,
        ORD_REF_OUTER  = 1'b1
    } walk_order_e;

    function automatic int unsigned idx_bits(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

    function automatic int unsigned tree_levels(input int unsigned leaves);
        return (leaves > 1) ? $clog2(leaves) : 0;
    endfunction

endpackage

// File: rtl/mdist_pair_walker.sv
module mdist_pair_walker
    import mdist_pkg::*;
#(
    parameter int unsigned NUM_SAMP = 4,
    parameter int unsigned NUM_REF  = 3,
    localparam int unsigned N_W = idx_bits(NUM_SAMP),
    localparam int unsigned K_W = idx_bits(NUM_REF)
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           ref_outer,
    output logic           busy,
    output logic [N_W-1:0] cur_n,
    output logic [K_W-1:0] cur_k,
    output logic           is_last
);
    localparam logic [N_W-1:0] N_LAST = N_W'(NUM_SAMP - 1);
    localparam logic [K_W-1:0] K_LAST = K_W'(NUM_REF - 1);

    typedef struct packed {
        logic           busy;
        walk_order_e    order;
        logic [N_W-1:0] n;
        logic [K_W-1:0] k;
    } walk_t;

    walk_t st_d, st_q;
    logic  at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.n == N_LAST) && (st_q.k == K_LAST);
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.order = walk_order_e'(ref_outer);
                st_d.n     = '0;
                st_d.k     = '0;
            end
        end else if (at_end) begin
            st_d.busy = 1'b0;
            st_d.n    = '0;
            st_d.k    = '0;
        end else if (st_q.order == ORD_SAMP_OUTER) begin
            if (st_q.k == K_LAST) begin
                st_d.k = '0;
                st_d.n = st_q.n + 1'b1;
            end else begin
                st_d.k = st_q.k + 1'b1;
            end
        end else begin
            if (st_q.n == N_LAST) begin
                st_d.n = '0;
                st_d.k = st_q.k + 1'b1;
            end else begin
                st_d.n = st_q.n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign cur_n   = st_q.n;
    assign cur_k   = st_q.k;
    assign is_last = st_q.busy && at_end;

endmodule

// File: rtl/mdist_absdiff_lanes.sv
module mdist_absdiff_lanes #(
    parameter int unsigned NUM_FEAT = 5,
    parameter int unsigned DATA_W   = 8,
    localparam int unsigned VEC_W = NUM_FEAT * DATA_W
)(
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    output logic [VEC_W-1:0] lane_abs
);
    for (genvar m = 0; m < NUM_FEAT; m++) begin : g_lane
        logic [DATA_W-1:0] a_m;
        logic [DATA_W-1:0] b_m;
        assign a_m = vec_a[m*DATA_W +: DATA_W];
        assign b_m = vec_b[m*DATA_W +: DATA_W];
        assign lane_abs[m*DATA_W +: DATA_W] = (a_m >= b_m) ? (a_m - b_m) : (b_m - a_m);
    end

endmodule

// File: rtl/mdist_adder_tree.sv
module mdist_adder_tree
    import mdist_pkg::*;
#(
    parameter int unsigned NUM_FEAT    = 5,
    parameter int unsigned DATA_W      = 8,
    parameter bit          PIPE_LEVELS = 1'b1,
    localparam int unsigned LVLS   = tree_levels(NUM_FEAT),
    localparam int unsigned LEAVES = 1 << LVLS,
    localparam int unsigned SUM_W  = DATA_W + LVLS
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_FEAT*DATA_W-1:0] lane_abs,
    output logic [SUM_W-1:0]           sum
);
    // lvl[l] holds the operands seen by level l; add_c[l] its pairwise sums
    logic [SUM_W-1:0] lvl   [LVLS+1][LEAVES];
    logic [SUM_W-1:0] add_c [LVLS][LEAVES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_FEAT) begin : g_used
            assign lvl[0][i] = SUM_W'(lane_abs[i*DATA_W +: DATA_W]);
        end else begin : g_pad
            assign lvl[0][i] = '0;
        end
    end

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        for (genvar i = 0; i < LEAVES; i++) begin : g_node
            if (i < (LEAVES >> (l + 1))) begin : g_add
                assign add_c[l][i] = lvl[l][2*i] + lvl[l][2*i+1];
            end else begin : g_idle
                assign add_c[l][i] = '0;
            end
        end
    end

    if (PIPE_LEVELS) begin : g_pipe
        logic [SUM_W-1:0] stg_q [LVLS][LEAVES];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int l = 0; l < LVLS; l++) begin
                    for (int i = 0; i < LEAVES; i++) begin
                        stg_q[l][i] <= '0;
                    end
                end
            end else begin
                stg_q <= add_c;
            end
        end

        for (genvar l = 0; l < LVLS; l++) begin : g_up
            for (genvar i = 0; i < LEAVES; i++) begin : g_cp
                assign lvl[l+1][i] = stg_q[l][i];
            end
        end
        assign sum = lvl[LVLS][0];
    end else begin : g_comb
        logic [SUM_W-1:0] sum_q;

        for (genvar l = 0; l < LVLS; l++) begin : g_up
            for (genvar i = 0; i < LEAVES; i++) begin : g_cp
                assign lvl[l+1][i] = add_c[l][i];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum_q <= '0;
            end else begin
                sum_q <= lvl[LVLS][0];
            end
        end
        assign sum = sum_q;
    end

endmodule

// File: rtl/mdist_tag_pipe.sv
module mdist_tag_pipe #(
    parameter int unsigned N_W   = 2,
    parameter int unsigned K_W   = 2,
    parameter int unsigned DEPTH = 3
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           in_last,
    input  logic [N_W-1:0] in_n,
    input  logic [K_W-1:0] in_k,
    output logic           out_valid,
    output logic           out_last,
    output logic [N_W-1:0] out_n,
    output logic [K_W-1:0] out_k
);
    typedef struct packed {
        logic           valid;
        logic           last;
        logic [N_W-1:0] n;
        logic [K_W-1:0] k;
    } tag_t;

    tag_t tag_d [DEPTH];
    tag_t tag_q [DEPTH];

    always_comb begin
        tag_d[0].valid = in_valid;
        tag_d[0].last  = in_last;
        tag_d[0].n     = in_n;
        tag_d[0].k     = in_k;
        for (int s = 1; s < DEPTH; s++) begin
            tag_d[s] = tag_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                tag_q[s] <= '0;
            end
        end else begin
            tag_q <= tag_d;
        end
    end

    assign out_valid = tag_q[DEPTH-1].valid;
    assign out_last  = tag_q[DEPTH-1].last;
    assign out_n     = tag_q[DEPTH-1].n;
    assign out_k     = tag_q[DEPTH-1].k;

endmodule

// File: rtl/mdist_tree_unit.sv
module mdist_tree_unit
    import mdist_pkg::*;
#(
    parameter int unsigned NUM_FEAT    = 5,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned NUM_SAMP    = 4,
    parameter int unsigned NUM_REF     = 3,
    parameter bit          PIPE_LEVELS = 1'b1,
    localparam int unsigned TREE_LVLS = tree_levels(NUM_FEAT),
    localparam int unsigned SUM_W     = DATA_W + TREE_LVLS,
    localparam int unsigned N_W       = idx_bits(NUM_SAMP),
    localparam int unsigned K_W       = idx_bits(NUM_REF),
    localparam int unsigned VEC_W     = NUM_FEAT * DATA_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ref_outer,
    output logic [N_W-1:0]   req_n,
    output logic [K_W-1:0]   req_k,
    input  logic [VEC_W-1:0] samp_vec,
    input  logic [VEC_W-1:0] ref_vec,
    output logic             out_valid,
    output logic [N_W-1:0]   out_n,
    output logic [K_W-1:0]   out_k,
    output logic [SUM_W-1:0] out_dist,
    output logic             done
);
    // NUM_FEAT must be at least 2 so the tree has one or more levels
    localparam int unsigned LAT = PIPE_LEVELS ? TREE_LVLS : 1;

    logic             walk_busy;
    logic             walk_last;
    logic [VEC_W-1:0] lane_abs;
    logic             res_last;
    logic             done_d, done_q;

    mdist_pair_walker #(
        .NUM_SAMP (NUM_SAMP),
        .NUM_REF  (NUM_REF)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ref_outer (ref_outer),
        .busy      (walk_busy),
        .cur_n     (req_n),
        .cur_k     (req_k),
        .is_last   (walk_last)
    );

    mdist_absdiff_lanes #(
        .NUM_FEAT (NUM_FEAT),
        .DATA_W   (DATA_W)
    ) u_lanes (
        .vec_a    (samp_vec),
        .vec_b    (ref_vec),
        .lane_abs (lane_abs)
    );

    mdist_adder_tree #(
        .NUM_FEAT    (NUM_FEAT),
        .DATA_W      (DATA_W),
        .PIPE_LEVELS (PIPE_LEVELS)
    ) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_abs (lane_abs),
        .sum      (out_dist)
    );

    mdist_tag_pipe #(
        .N_W   (N_W),
        .K_W   (K_W),
        .DEPTH (LAT)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (walk_busy),
        .in_last   (walk_last),
        .in_n      (req_n),
        .in_k      (req_k),
        .out_valid (out_valid),
        .out_last  (res_last),
        .out_n     (out_n),
        .out_k     (out_k)
    );

    always_comb begin
        done_d = out_valid && res_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_d;
        end
    end

    assign done = done_q;

endmodule

// File: rtl/mdist_tree_unit_chk.sv
module mdist_tree_unit_chk #(
    parameter int unsigned NUM_SAMP = 4,
    parameter int unsigned NUM_REF  = 3,
    parameter int unsigned NUM_FEAT = 5,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned SUM_W    = 11,
    parameter int unsigned N_W      = 2,
    parameter int unsigned K_W      = 2
)(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             walk_busy,
    input logic [N_W-1:0]   req_n,
    input logic [K_W-1:0]   req_k,
    input logic             out_valid,
    input logic [N_W-1:0]   out_n,
    input logic [K_W-1:0]   out_k,
    input logic [SUM_W-1:0] out_dist,
    input logic             done
);
    localparam logic [N_W-1:0]   N_LAST   = N_W'(NUM_SAMP - 1);
    localparam logic [K_W-1:0]   K_LAST   = K_W'(NUM_REF - 1);
    localparam logic [SUM_W-1:0] MAX_DIST = SUM_W'(NUM_FEAT * ((1 << DATA_W) - 1));

    p_first_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !walk_busy) |=> (walk_busy && req_n == '0 && req_k == '0));

    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_n <= N_LAST && out_k <= K_LAST));

    p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_n == N_LAST && out_k == K_LAST)) |=> out_valid);

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid) && $past(out_n) == N_LAST && $past(out_k) == K_LAST));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_dist <= MAX_DIST));

endmodule

bind mdist_tree_unit mdist_tree_unit_chk #(
    .NUM_SAMP (NUM_SAMP),
    .NUM_REF  (NUM_REF),
    .NUM_FEAT (NUM_FEAT),
    .DATA_W   (DATA_W),
    .SUM_W    (SUM_W),
    .N_W      (N_W),
    .K_W      (K_W)
) u_chk (.*);

// File: tb/mdist_tree_unit_test.sv
module mdist_tree_unit_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int M    = 5;
    localparam int DW   = 8;
    localparam int NS   = 4;
    localparam int NR   = 3;
    localparam int NW   = 2;
    localparam int KW   = 2;
    localparam int SW   = 11;
    localparam int VW   = M * DW;
    localparam int LATP = 3;
    localparam int LATC = 1;
    localparam int RUNC = 24;

    // rows: {walk order, data seed, cycle of an extra start pulse (0 = none)}
    localparam int JOBS [6][3] = '{
        '{0, 0, 0},
        '{1, 1, 0},
        '{0, 2, 0},
        '{1, 3, 0},
        '{0, 4, 5},
        '{1, 5, 7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ref_outer = 1'b0;

    logic [NW-1:0] req_n_p, req_n_c, out_n_p, out_n_c;
    logic [KW-1:0] req_k_p, req_k_c, out_k_p, out_k_c;
    logic [VW-1:0] sv_p, rv_p, sv_c, rv_c;
    logic [SW-1:0] dist_p, dist_c;
    logic          val_p, val_c, done_p, done_c;

    logic [DW-1:0] smem [NS][M];
    logic [DW-1:0] rmem [NR][M];

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mdist_tree_unit #(.NUM_FEAT(M), .DATA_W(DW), .NUM_SAMP(NS), .NUM_REF(NR), .PIPE_LEVELS(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_outer(ref_outer),
        .req_n(req_n_p), .req_k(req_k_p), .samp_vec(sv_p), .ref_vec(rv_p),
        .out_valid(val_p), .out_n(out_n_p), .out_k(out_k_p), .out_dist(dist_p), .done(done_p));

    mdist_tree_unit #(.NUM_FEAT(M), .DATA_W(DW), .NUM_SAMP(NS), .NUM_REF(NR), .PIPE_LEVELS(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_outer(ref_outer),
        .req_n(req_n_c), .req_k(req_k_c), .samp_vec(sv_c), .ref_vec(rv_c),
        .out_valid(val_c), .out_n(out_n_c), .out_k(out_k_c), .out_dist(dist_c), .done(done_c));

    // same-cycle memories addressed by each copy
    always_comb begin
        for (int m = 0; m < M; m++) begin
            sv_p[m*DW +: DW] = smem[req_n_p][m];
            rv_p[m*DW +: DW] = rmem[req_k_p][m];
            sv_c[m*DW +: DW] = smem[req_n_c][m];
            rv_c[m*DW +: DW] = rmem[req_k_c][m];
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int n = 0; n < NS; n++)
            for (int m = 0; m < M; m++)
                smem[n][m] = (seed == 0) ? 8'd0 : DW'((seed * 37 + n * 53 + m * 29) & 255);
        for (int k = 0; k < NR; k++)
            for (int m = 0; m < M; m++)
                rmem[k][m] = (seed == 0) ? 8'd255 :
                             (seed == 1) ? smem[k][m] : DW'((seed * 11 + k * 71 + m * 97 + 13) & 255);
    endtask

    function automatic int exp_dist(input int n, input int k);
        int acc = 0;
        for (int m = 0; m < M; m++) begin
            int a = int'(smem[n][m]);
            int b = int'(rmem[k][m]);
            acc += (a > b) ? a - b : b - a;
        end
        return acc;
    endfunction

    task automatic observe(input string tag, input int lat, input int cyc, input bit ord, input int seed,
                           input logic v, input logic [NW-1:0] on, input logic [KW-1:0] ok,
                           input logic [SW-1:0] od, input logic dn, ref int got, ref int dones);
        if (v) begin
            int en = ord ? got % NS : got / NR;
            int ek = ord ? got / NS : got % NR;
            check_eq(ord ? "R5" : "R4", {tag, " sample index"}, int'(on), en);
            check_eq(ord ? "R5" : "R4", {tag, " reference index"}, int'(ok), ek);
            check_eq(seed == 0 ? "R10" : "R1", {tag, " distance"}, int'(od), exp_dist(en, ek));
            check_eq("R2", {tag, " arrival cycle"}, cyc, lat + got);
            got++;
        end
        if (dn) begin
            check_eq("R7", {tag, " done cycle"}, cyc, lat + NS * NR);
            dones++;
        end
    endtask

    task automatic run_job(input bit ord, input int seed, input int again);
        int got_p = 0, got_c = 0, dn_p = 0, dn_c = 0;
        fill(seed);
        @(negedge clk);
        start = 1'b1;
        ref_outer = ord;
        @(negedge clk);
        start = 1'b0;
        ref_outer = ~ord;   // R8: change after acceptance has no effect
        for (int cyc = 0; cyc < RUNC; cyc++) begin
            if (cyc == 0) begin
                check_eq("R6", "pipelined first address n", int'(req_n_p), 0);
                check_eq("R6", "pipelined first address k", int'(req_k_p), 0);
                check_eq("R6", "combinational first address n", int'(req_n_c), 0);
                check_eq("R6", "combinational first address k", int'(req_k_c), 0);
            end
            observe("pipelined", LATP, cyc, ord, seed, val_p, out_n_p, out_k_p, dist_p, done_p, got_p, dn_p);
            observe("combinational", LATC, cyc, ord, seed, val_c, out_n_c, out_k_c, dist_c, done_c, got_c, dn_c);
            start = (again != 0 && cyc == again);
            if (again != 0 && cyc == again) ref_outer = ord;
            @(negedge clk);
            ref_outer = ~ord;
        end
        start = 1'b0;
        check_eq("R3", "pipelined result count", got_p, NS * NR);
        check_eq("R3", "combinational result count", got_c, NS * NR);
        check_eq(again != 0 ? "R8" : "R7", "pipelined done count", dn_p, 1);
        check_eq(again != 0 ? "R8" : "R7", "combinational done count", dn_c, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        fill(2);
        repeat (4) @(negedge clk);
        // R9: outputs idle in and after reset
        check_eq("R9", "pipelined valid in reset", int'(val_p), 0);
        check_eq("R9", "combinational done in reset", int'(done_c), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check_eq("R9", "pipelined valid idle", int'(val_p), 0);
            check_eq("R9", "combinational valid idle", int'(val_c), 0);
            check_eq("R9", "done idle", int'(done_p | done_c), 0);
        end

        for (int j = 0; j < 6; j++) begin
            run_job(JOBS[j][0] != 0, JOBS[j][1], JOBS[j][2]);
        end

        // R9: reset in mid-run, run must not resume
        @(negedge clk);
        start = 1'b1;
        ref_outer = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_eq("R9", "pipelined valid during reset", int'(val_p), 0);
        check_eq("R9", "combinational valid during reset", int'(val_c), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < RUNC; i++) begin
            @(negedge clk);
            check_eq("R9", "valid after aborted run", int'(val_p | val_c), 0);
            check_eq("R9", "done after aborted run", int'(done_p | done_c), 0);
        end

        run_job(1'b1, 6, 0);

        summary();
        $finish;
    end

endmodule